// File: doc/BRIEF.md
# NOR Flash Command Front End

This block is the command-decoding front end of an asynchronous parallel NOR flash device. It runs on a fast internal clock and samples the active-low chip-enable, output-enable and write-enable pins, the address bus, the data bus and a supply-lockout flag that an external comparator drives. A write cycle counts only when the pin combination is valid and stays valid long enough to rule out a noise pulse. The command is taken when the write cycle ends. The block tracks three modes: array read, identification (autoselect) and parameter query. It also produces the read data for each mode.

After reset the block is in array read. If the pins already show a write when reset releases, that write is not taken as a command. While the lockout flag is high, every write is ignored and the mode is forced back to array read. In query mode, reads index a small computed table. Only the exit command or the lockout leaves query mode.

Top module: `nfc_cmd_front`

## Requirements
- R1: During and directly after reset, `mode_o` is 2'b00 (array read) and `rd_data` is 8'h00.
- R2: A write cycle exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1 together. A hold with `oe_n` low, `ce_n` high or `we_n` high is never taken as a command.
- R3: The write condition must be sampled on GLITCH_CYC consecutive clocks (3 with defaults, covering 5 ns at a 2 ns clock). A shorter write is ignored.
- R4: The command is the address and data last sampled during the write. It takes effect when the write condition ends, and `mode_o` shows the new mode after the third rising clock edge following the release.
- R5: Data F0h written to any address returns the block to array read (2'b00) from any mode.
- R6: Data 98h written to address 55h enters query mode (2'b10) from array read or from autoselect. 98h at any other address has no effect.
- R7: Data 90h written to any address in array read enters autoselect (2'b01). In query mode, 90h has no effect.
- R8: Query mode is left only by F0h or by the lockout. Any other data keeps the mode at 2'b10.
- R9: If the write condition is active when reset releases, it is not counted until the pins have been seen inactive once. Its release issues no command.
- R10: While `vdd_low` is 1, writes are ignored. `mode_o` is 2'b00 after the second rising edge following the assertion of `vdd_low`.
- R11: `rd_data` is registered and reflects the pins after the second rising edge. With `ce_n`=0 and `oe_n`=0 the output depends on the mode. In array read it is `arr_rdata`. In autoselect it is MFR_ID at address 0, DEV_ID at address 1 and 0 at other addresses. Otherwise `rd_data` is 8'h00.
- R12: In query mode with `ce_n`=`oe_n`=0, `rd_data` is table byte `addr` when `addr` < CFI_DEPTH (16) and 0 otherwise. Bytes 0 to 2 are 51h, 52h and 59h. Byte i≥3 is ((i*29) mod 256) XOR 5Ah.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address bus |
| din | input | 8 | Data bus, write direction |
| arr_rdata | input | 8 | Data from the storage array for array-read mode |
| vdd_low | input | 1 | Low-supply lockout flag from the comparator |
| rd_data | output | 8 | Read data for the current mode |
| mode_o | output | 2 | Current mode: 00 array read, 01 autoselect, 10 query |

## Verification
Each result has a fixed latency. A mode change from a qualified write appears after the third rising edge following the write's release: one edge for the input sample, one for the command strobe and one for the mode register. A lockout forces array read after the second edge. Read data follows the pins after the second edge. The bench's reference model advances once per rising edge with exactly those delays and is compared against both outputs on every falling edge. Targeted checks also confirm the boundary cycles: the mode is unchanged two edges after a release and updated on the third.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_CFI  = 2'b10
    } nfc_mode_e;

    localparam logic [7:0] OP_EXIT  = 8'hF0;
    localparam logic [7:0] OP_IDENT = 8'h90;
    localparam logic [7:0] OP_QUERY = 8'h98;
    localparam int         QUERY_ADDR = 'h55;

    // Query table contents: a fixed signature, then a computed pattern
    function automatic logic [7:0] query_byte(input int idx);
        case (idx)
            0:       return 8'h51;
            1:       return 8'h52;
            2:       return 8'h59;
            default: return 8'(idx * 29) ^ 8'h5A;
        endcase
    endfunction

endpackage

// File: rtl/nfc_wr_qual.sv
module nfc_wr_qual
    import nfc_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic              vlow_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [7:0]        din_s,
    output logic              cmd_vld,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data
);

    localparam int              CNT_W    = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(GLITCH_CYC);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              pu_blk;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              strobe;
    } qual_t;

    qual_t qual_d, qual_q;
    logic  wr_act;

    always_comb begin
        wr_act = !ce_s && !we_s && oe_s;
        qual_d = qual_q;
        // Command fires when a long-enough write ends outside lockout
        qual_d.strobe = !wr_act && (qual_q.cnt == CNT_FULL) && !vlow_s;
        if (wr_act) begin
            qual_d.addr = addr_s;
            qual_d.data = din_s;
        end
        if (vlow_s || !wr_act) begin
            qual_d.cnt = '0;
        end else if (!qual_q.pu_blk && (qual_q.cnt != CNT_FULL)) begin
            qual_d.cnt = qual_q.cnt + 1'b1;
        end
        // Power-up block lifts once the pins are seen idle
        qual_d.pu_blk = qual_q.pu_blk && wr_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '{cnt: '0, pu_blk: 1'b1, addr: '0, data: '0, strobe: 1'b0};
        end else begin
            qual_q <= qual_d;
        end
    end

    assign cmd_vld  = qual_q.strobe;
    assign cmd_addr = qual_q.addr;
    assign cmd_data = qual_q.data;

    AST_FILTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q.strobe |-> $past(qual_q.cnt) == CNT_FULL); // R3

    AST_PU_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q.pu_blk |-> qual_q.cnt == '0); // R9

endmodule

// File: rtl/nfc_mode_fsm.sv
module nfc_mode_fsm
    import nfc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vlow_s,
    input  logic              cmd_vld,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output nfc_mode_e         mode
);

    nfc_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (vlow_s) begin
            mode_d = MODE_READ;
        end else if (cmd_vld) begin
            case (cmd_data)
                OP_EXIT:  mode_d = MODE_READ;
                OP_IDENT: if (mode_q == MODE_READ) mode_d = MODE_AUTO;
                OP_QUERY: if ((cmd_addr == ADDR_W'(QUERY_ADDR)) && (mode_q != MODE_CFI))
                              mode_d = MODE_CFI;
                default:  mode_d = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_READ;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    AST_QUERY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CFI) |=> (mode_q == MODE_CFI) || $past(vlow_s) ||
                                 ($past(cmd_vld) && ($past(cmd_data) == OP_EXIT))); // R8

endmodule

// File: rtl/nfc_rd_path.sv
module nfc_rd_path
    import nfc_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         CFI_DEPTH = 16,
    parameter logic [7:0] MFR_ID    = 8'hA7,
    parameter logic [7:0] DEV_ID    = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              oe_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [7:0]        arr_s,
    input  nfc_mode_e         mode,
    output logic [7:0]        rd_data
);

    localparam int IDX_W = $clog2(CFI_DEPTH);

    logic [7:0] rom [CFI_DEPTH];
    logic [7:0] rd_d, rd_q;

    for (genvar g = 0; g < CFI_DEPTH; g++) begin : g_rom
        assign rom[g] = query_byte(g);
    end

    always_comb begin
        rd_d = 8'h00;
        if (!ce_s && !oe_s) begin
            case (mode)
                MODE_READ: rd_d = arr_s;
                MODE_AUTO: begin
                    if (addr_s == '0)                rd_d = MFR_ID;
                    else if (addr_s == ADDR_W'(1))   rd_d = DEV_ID;
                end
                MODE_CFI: if (int'(addr_s) < CFI_DEPTH) rd_d = rom[addr_s[IDX_W-1:0]];
                default:  rd_d = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 8'h00;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_s || oe_s) |-> rd_q == 8'h00); // R11

endmodule

// File: rtl/nfc_cmd_front.sv
module nfc_cmd_front
    import nfc_pkg::*;
#(
    parameter int         ADDR_W        = 8,
    parameter int         CLK_PERIOD_PS = 2000,
    parameter int         GLITCH_PS     = 5000,
    parameter int         CFI_DEPTH     = 16,
    parameter logic [7:0] MFR_ID        = 8'hA7,
    parameter logic [7:0] DEV_ID        = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        arr_rdata,
    input  logic              vdd_low,
    output logic [7:0]        rd_data,
    output logic [1:0]        mode_o
);

    localparam int GLITCH_CYC = (GLITCH_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    typedef struct packed {
        logic              ce;
        logic              we;
        logic              oe;
        logic              vlow;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        din;
        logic [7:0]        arr;
    } samp_t;

    samp_t samp_d, samp_q;

    logic              cmd_vld;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    nfc_mode_e         mode_w;

    always_comb begin
        samp_d = '{ce: ce_n, we: we_n, oe: oe_n, vlow: vdd_low,
                   addr: addr, din: din, arr: arr_rdata};
    end

    // Reset value looks like a write in progress under lockout
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '{ce: 1'b0, we: 1'b0, oe: 1'b1, vlow: 1'b1,
                        addr: '0, din: '0, arr: '0};
        end else begin
            samp_q <= samp_d;
        end
    end

    nfc_wr_qual #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_s     (samp_q.ce),
        .we_s     (samp_q.we),
        .oe_s     (samp_q.oe),
        .vlow_s   (samp_q.vlow),
        .addr_s   (samp_q.addr),
        .din_s    (samp_q.din),
        .cmd_vld  (cmd_vld),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data)
    );

    nfc_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vlow_s   (samp_q.vlow),
        .cmd_vld  (cmd_vld),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .mode     (mode_w)
    );

    nfc_rd_path #(.ADDR_W(ADDR_W), .CFI_DEPTH(CFI_DEPTH),
                  .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (samp_q.ce),
        .oe_s    (samp_q.oe),
        .addr_s  (samp_q.addr),
        .arr_s   (samp_q.arr),
        .mode    (mode_w),
        .rd_data (rd_data)
    );

    assign mode_o = mode_w;

    AST_LOCKOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        samp_q.vlow |=> mode_o == MODE_READ); // R10

endmodule

// File: tb/nfc_cmd_front_test.sv
module nfc_cmd_front_test;

    localparam int CLK_PERIOD = 10;
    localparam int G          = 3;   // 5 ns filter at a 2 ns sample clock

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0, vdd_low = 1'b0;
    logic [7:0] addr = 8'h55, din = 8'h98, arr_rdata = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] mode_o;

    int    n_cmp = 0, n_bad = 0;
    bit    armed = 1'b0, done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    nfc_cmd_front uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .arr_rdata(arr_rdata), .vdd_low(vdd_low),
        .rd_data(rd_data), .mode_o(mode_o)
    );

    // ---------------- reference model ----------------
    int         m_mode = 0, run = 0;
    bit         pu = 1'b1;
    int         exp_rd = 0;
    bit         p1_v = 0, p2_v = 0;
    logic [7:0] p1_a, p1_d, p2_a, p2_d, lat_a = 0, lat_d = 0;
    bit         pv_ce = 0, pv_oe = 1, pv_vlow = 1;
    logic [7:0] pv_addr = 0, pv_arr = 0;

    function automatic int qb(int i);
        if (i == 0) return 'h51;
        if (i == 1) return 'h52;
        if (i == 2) return 'h59;
        return ((i * 29) % 256) ^ 'h5A;
    endfunction

    function automatic int read_val(int md, bit c, bit o, int a, int arr);
        if (c || o) return 0;
        if (md == 0) return arr;
        if (md == 1) return (a == 0) ? 'hA7 : (a == 1) ? 'h3C : 0;
        return (a < 16) ? qb(a) : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; run = 0; pu = 1; exp_rd = 0; p1_v = 0; p2_v = 0;
            lat_a = 0; lat_d = 0; pv_ce = 0; pv_oe = 1; pv_vlow = 1;
            pv_addr = 0; pv_arr = 0;
        end else begin
            bit act;
            exp_rd = read_val(m_mode, pv_ce, pv_oe, pv_addr, pv_arr);
            if (pv_vlow) m_mode = 0;
            else if (p2_v) begin
                if (p2_d == 8'hF0) m_mode = 0;
                else if (p2_d == 8'h90 && m_mode == 0) m_mode = 1;
                else if (p2_d == 8'h98 && p2_a == 8'h55 && m_mode != 2) m_mode = 2;
            end
            p2_v = p1_v; p2_a = p1_a; p2_d = p1_d;
            act  = !ce_n && !we_n && oe_n;
            p1_v = !act && (run >= G) && !vdd_low;
            p1_a = lat_a; p1_d = lat_d;
            if (act) begin lat_a = addr; lat_d = din; end
            if (vdd_low || !act) run = 0;
            else if (!pu && run < G) run++;
            pu = pu && act;
            pv_ce = ce_n; pv_oe = oe_n; pv_vlow = vdd_low;
            pv_addr = addr; pv_arr = arr_rdata;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, int act_v, int exp_v);
        n_cmp++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            chk(cur_req, int'(mode_o), m_mode);
            chk(cur_req, int'(rd_data), exp_rd);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d, int w, string req);
        cur_req = req;
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
        step(w);
        ce_n = 1; we_n = 1;
        step(4);
    endtask

    task automatic hold_pins(bit c, bit w, bit o, int n, string req);
        cur_req = req;
        ce_n = c; we_n = w; oe_n = o; addr = 8'h55; din = 8'h98;
        step(n);
        ce_n = 1; we_n = 1; oe_n = 1;
        step(4);
    endtask

    task automatic rd(logic [7:0] a, int expv, string req);
        cur_req = req;
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        step(2);
        chk(req, int'(rd_data), expv);
        ce_n = 1; oe_n = 1;
        step(1);
    endtask

    initial begin
        step(3);
        armed = 1;
        chk("R1", int'(mode_o), 0);
        chk("R1", int'(rd_data), 0);
        rst_n = 1;
        cur_req = "R9";                     // write pins active across reset release
        step(8);
        ce_n = 1; we_n = 1;
        step(4);
        chk("R9", int'(mode_o), 0);

        arr_rdata = 8'h5A;
        rd(8'h10, 'h5A, "R11");
        cur_req = "R11"; ce_n = 0; oe_n = 1; step(2);
        chk("R11", int'(rd_data), 0);
        ce_n = 1; step(1);

        wr(8'h55, 8'h98, G - 1, "R3");
        chk("R3", int'(mode_o), 0);
        wr(8'h55, 8'h98, 1, "R3");
        chk("R3", int'(mode_o), 0);

        cur_req = "R4";
        ce_n = 0; we_n = 0; oe_n = 1; addr = 8'h55; din = 8'h98;
        step(G);
        ce_n = 1; we_n = 1;
        step(2);
        chk("R4", int'(mode_o), 0);
        step(1);
        chk("R4", int'(mode_o), 2);
        chk("R6", int'(mode_o), 2);
        step(2);

        rd(8'd0, 'h51, "R12");
        rd(8'd1, 'h52, "R12");
        rd(8'd2, 'h59, "R12");
        rd(8'd5, qb(5), "R12");
        rd(8'd15, qb(15), "R12");
        rd(8'd16, 0, "R12");
        rd(8'd200, 0, "R12");

        wr(8'h00, 8'h90, G, "R7");
        chk("R7", int'(mode_o), 2);
        wr(8'h03, 8'h42, G, "R8");
        chk("R8", int'(mode_o), 2);
        wr(8'h55, 8'h98, G + 2, "R8");
        chk("R8", int'(mode_o), 2);
        wr(8'h77, 8'hF0, G, "R5");
        chk("R5", int'(mode_o), 0);

        hold_pins(0, 0, 0, 6, "R2");
        chk("R2", int'(mode_o), 0);
        hold_pins(1, 0, 1, 6, "R2");
        chk("R2", int'(mode_o), 0);
        hold_pins(0, 1, 1, 6, "R2");
        chk("R2", int'(mode_o), 0);

        wr(8'h33, 8'h90, G, "R7");
        chk("R7", int'(mode_o), 1);
        rd(8'd0, 'hA7, "R11");
        rd(8'd1, 'h3C, "R11");
        rd(8'd2, 0, "R11");
        wr(8'h55, 8'h98, G, "R6");
        chk("R6", int'(mode_o), 2);
        wr(8'h56, 8'hF0, G, "R5");
        chk("R5", int'(mode_o), 0);
        wr(8'h56, 8'h98, G, "R6");
        chk("R6", int'(mode_o), 0);

        cur_req = "R10";
        vdd_low = 1; step(1);
        wr(8'h55, 8'h98, G + 1, "R10");
        chk("R10", int'(mode_o), 0);
        vdd_low = 0; step(1);
        wr(8'h55, 8'h98, G, "R10");
        chk("R10", int'(mode_o), 2);
        vdd_low = 1;
        step(2);
        chk("R10", int'(mode_o), 0);
        vdd_low = 0; step(1);
        wr(8'h10, 8'h90, G, "R10");
        chk("R10", int'(mode_o), 1);
        wr(8'h00, 8'hF0, G, "R5");
        chk("R5", int'(mode_o), 0);

        step(2);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule